// File: doc/BRIEF.md
# SCSI Initiator Status and Interrupt Register File

This block is the software-visible register file of a SCSI initiator controller. It holds 16-bit registers on a simple word-aligned bus with a write strobe, a byte address, write data and a read-data mux. The registers are a control word whose bit 0 enables interrupts, a 3-bit bus ID, a 3-bit target selector, a read-only selection-detector status, a byte-wide data register and a two-bit transfer-mode field. It also holds two status words, one for connection state and one for data transfer.

The bus engine outside the block reports events in two ways. Single-cycle set pulses raise the sticky condition bits, and software clears those bits by writing ones. Level inputs drive the read-only bits, such as the bus phase, and the block registers them. Both status words show the same two summary flags in their top bits. The connection flag is the OR of the connection conditions and the data flag is the OR of the data conditions. A single level interrupt line is raised while interrupts are enabled and either flag is set.

Top module: `scsi_stat_regs`

## Requirements
- R1: While reset is low, and after it, every register reads zero and `irq` is low until an input changes them.
- R2: Connection status (offset 0x48), sticky bits 13, 12, 11, 9, 8, 7 and 3. A `conn_set` pulse sets the bit at the next clock edge. A write of 1 clears the bit, and a write of 0 leaves it unchanged.
- R3: Connection status, other bits. Bits 6:4 and 2:0 read the value `conn_lvl` had one clock earlier, and writes do not change them. Bit 10 takes the written value.
- R4: Data status (offset 0x4C). Bits 13, 11, 10, 4 and 3 are sticky: a `data_set` pulse sets them and a write of 1 clears them. Bits 2:0 read `data_lvl` from one clock earlier and ignore writes. Bits 12 and 9:5 take the written value.
- R5: Bit 15 of both status words is the OR of connection bits 13, 12, 11, 9, 8 and 7.
- R6: Bit 14 of both status words is the OR of data bits 13, 11, 10 and 4.
- R7: `irq` is high exactly when control bit 0 (offset 0x0C, all 16 bits writable) is 1 and status bit 15 or bit 14 is 1.
- R8: A write keeps only bits 2:0 at the ID register (0x10) and at the selector register (0x14). It keeps only bits 1:0 at the transfer-mode register (0x24) and only bits 7:0 at the data register (0x20). All other bits read zero.
- R9: Offset 0x18 reads the value `det_id` had one clock earlier in bits 2:0, and writes to it change nothing.
- R10: A write whose address has bits 1:0 non-zero, or whose address is unmapped, changes no register. A read of such an address returns zero.
- R11: When a set pulse and a write of 1 hit the same sticky bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 7 | Byte address of the access |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for `addr`, combinational |
| conn_set | input | 16 | Set pulses for sticky connection bits |
| data_set | input | 16 | Set pulses for sticky data bits |
| conn_lvl | input | 16 | Levels for read-only connection bits |
| data_lvl | input | 16 | Levels for read-only data bits |
| det_id | input | 3 | Selection-detector ID level |
| irq | output | 1 | Level interrupt request |

## Verification
Random cycles mix sparse set pulses, random level values and writes to valid, misaligned and unmapped addresses. This separates the sticky, read-only and writable bit classes of each status word, and it shows whether a stray access leaks into a register. Directed steps aim at a set pulse and a write-one clear of the same bit in the same cycle, a write of zeros that must keep sticky bits, and each summary source on its own with the enable on and off. A write to the detector offset is also directed, and it must leave the value that was captured earlier. After every cycle, every register and the interrupt line are compared with a bench model.

// File: rtl/scsi_stat_pkg.sv
package scsi_stat_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 16;
  localparam int ID_W   = 3;
  localparam int MODE_W = 2;
  localparam int BYTE_W = 8;

  localparam logic [ADDR_W-1:0] OFF_CTRL = 7'h0C;
  localparam logic [ADDR_W-1:0] OFF_ID   = 7'h10;
  localparam logic [ADDR_W-1:0] OFF_SEL  = 7'h14;
  localparam logic [ADDR_W-1:0] OFF_DET  = 7'h18;
  localparam logic [ADDR_W-1:0] OFF_DATA = 7'h20;
  localparam logic [ADDR_W-1:0] OFF_MODE = 7'h24;
  localparam logic [ADDR_W-1:0] OFF_CST  = 7'h48;
  localparam logic [ADDR_W-1:0] OFF_DST  = 7'h4C;

  localparam int CI_BIT = 15;
  localparam int DI_BIT = 14;
  localparam int IE_BIT = 0;

  // connection status bit classes
  localparam logic [DATA_W-1:0] CST_W1C = 16'h3B88;
  localparam logic [DATA_W-1:0] CST_LVL = 16'h0077;
  localparam logic [DATA_W-1:0] CST_SW  = 16'h0400;
  localparam logic [DATA_W-1:0] CST_SUM = 16'h3B80;
  // data status bit classes
  localparam logic [DATA_W-1:0] DST_W1C = 16'h2C18;
  localparam logic [DATA_W-1:0] DST_LVL = 16'h0007;
  localparam logic [DATA_W-1:0] DST_SW  = 16'h13E0;
  localparam logic [DATA_W-1:0] DST_SUM = 16'h2C10;

  // next value of a status word; a set pulse dominates a clear
  function automatic logic [DATA_W-1:0] stat_next(
      input logic [DATA_W-1:0] old, input logic [DATA_W-1:0] wdata,
      input logic wr, input logic [DATA_W-1:0] set, input logic [DATA_W-1:0] lvl,
      input logic [DATA_W-1:0] w1c, input logic [DATA_W-1:0] lvlm,
      input logic [DATA_W-1:0] swm);
    logic [DATA_W-1:0] clr;
    logic [DATA_W-1:0] sw;
    clr = wr ? (wdata & w1c) : '0;
    sw  = wr ? wdata : old;
    return (((old & ~clr) | set) & w1c) | (lvl & lvlm) | (sw & swm);
  endfunction

  function automatic logic any_cond(input logic [DATA_W-1:0] word,
                                    input logic [DATA_W-1:0] mask);
    return |(word & mask);
  endfunction
endpackage

// File: rtl/scsi_status_word.sv
module scsi_status_word
  import scsi_stat_pkg::*;
#(
  parameter logic [DATA_W-1:0] W1C_MASK = '0,
  parameter logic [DATA_W-1:0] LVL_MASK = '0,
  parameter logic [DATA_W-1:0] SW_MASK  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] set,
  input  logic [DATA_W-1:0] lvl,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] q_nxt;

  always_comb q_nxt = stat_next(q, wdata, wr, set, lvl, W1C_MASK, LVL_MASK, SW_MASK);

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/scsi_cfg_regs.sv
module scsi_cfg_regs
  import scsi_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ID_W-1:0]   det_in,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [ID_W-1:0]   id_q,
  output logic [ID_W-1:0]   sel_q,
  output logic [ID_W-1:0]   det_q,
  output logic [BYTE_W-1:0] data_q,
  output logic [MODE_W-1:0] mode_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      id_q   <= '0;
      sel_q  <= '0;
      det_q  <= '0;
      data_q <= '0;
      mode_q <= '0;
    end else begin
      det_q <= det_in;
      if (wr_en) begin
        case (addr)
          OFF_CTRL: ctrl_q <= wr_data;
          OFF_ID:   id_q   <= wr_data[ID_W-1:0];
          OFF_SEL:  sel_q  <= wr_data[ID_W-1:0];
          OFF_DATA: data_q <= wr_data[BYTE_W-1:0];
          OFF_MODE: mode_q <= wr_data[MODE_W-1:0];
          default:  ;
        endcase
      end
    end
  end
endmodule

// File: rtl/scsi_irq_summary.sv
module scsi_irq_summary
  import scsi_stat_pkg::*;
(
  input  logic [DATA_W-1:0] cst_q,
  input  logic [DATA_W-1:0] dst_q,
  input  logic              ie,
  output logic              ci,
  output logic              di,
  output logic              irq
);
  always_comb begin
    ci  = any_cond(cst_q, CST_SUM);
    di  = any_cond(dst_q, DST_SUM);
    irq = ie & (ci | di);
  end
endmodule

// File: rtl/scsi_stat_regs.sv
module scsi_stat_regs
  import scsi_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W-1:0] conn_set,
  input  logic [DATA_W-1:0] data_set,
  input  logic [DATA_W-1:0] conn_lvl,
  input  logic [DATA_W-1:0] data_lvl,
  input  logic [ID_W-1:0]   det_id,
  output logic              irq
);
  logic              wr_cst;
  logic              wr_dst;
  logic [DATA_W-1:0] cst_q;
  logic [DATA_W-1:0] dst_q;
  logic [DATA_W-1:0] ctrl_q;
  logic [ID_W-1:0]   id_q;
  logic [ID_W-1:0]   sel_q;
  logic [ID_W-1:0]   det_q;
  logic [BYTE_W-1:0] data_q;
  logic [MODE_W-1:0] mode_q;
  logic              ci;
  logic              di;

  assign wr_cst = wr_en && (addr == OFF_CST);
  assign wr_dst = wr_en && (addr == OFF_DST);

  scsi_status_word #(.W1C_MASK(CST_W1C), .LVL_MASK(CST_LVL), .SW_MASK(CST_SW)) u_cst (
    .clk(clk), .rst_n(rst_n), .wr(wr_cst), .wdata(wr_data),
    .set(conn_set), .lvl(conn_lvl), .q(cst_q));

  scsi_status_word #(.W1C_MASK(DST_W1C), .LVL_MASK(DST_LVL), .SW_MASK(DST_SW)) u_dst (
    .clk(clk), .rst_n(rst_n), .wr(wr_dst), .wdata(wr_data),
    .set(data_set), .lvl(data_lvl), .q(dst_q));

  scsi_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .det_in(det_id), .ctrl_q(ctrl_q), .id_q(id_q), .sel_q(sel_q),
    .det_q(det_q), .data_q(data_q), .mode_q(mode_q));

  scsi_irq_summary u_sum (
    .cst_q(cst_q), .dst_q(dst_q), .ie(ctrl_q[IE_BIT]),
    .ci(ci), .di(di), .irq(irq));

  always_comb begin
    rd_data = '0;
    case (addr)
      OFF_CTRL: rd_data = ctrl_q;
      OFF_ID:   rd_data[ID_W-1:0]   = id_q;
      OFF_SEL:  rd_data[ID_W-1:0]   = sel_q;
      OFF_DET:  rd_data[ID_W-1:0]   = det_q;
      OFF_DATA: rd_data[BYTE_W-1:0] = data_q;
      OFF_MODE: rd_data[MODE_W-1:0] = mode_q;
      OFF_CST: begin
        rd_data = cst_q;
        rd_data[CI_BIT] = ci;
        rd_data[DI_BIT] = di;
      end
      OFF_DST: begin
        rd_data = dst_q;
        rd_data[CI_BIT] = ci;
        rd_data[DI_BIT] = di;
      end
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/scsi_stat_regs_chk.sv
module scsi_stat_regs_chk
  import scsi_stat_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] conn_set,
  input logic [DATA_W-1:0] data_set,
  input logic [DATA_W-1:0] conn_lvl,
  input logic [DATA_W-1:0] cst_q,
  input logic [DATA_W-1:0] dst_q,
  input logic [DATA_W-1:0] ctrl_q,
  input logic              irq
);
  // R2: a pulse sets the sticky bit at the next edge
  p_set_sticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    conn_set[13] |=> cst_q[13]);

  // R2: write of one clears when no pulse competes
  p_w1c_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFF_CST && wr_data[8] && !conn_set[8]) |=> !cst_q[8]);

  // R2: without pulse and without write the sticky bit holds
  p_sticky_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !conn_set[9]) |=> (cst_q[9] == $past(cst_q[9])));

  // R3: read-only bits track the level input, writes or not
  p_level_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFF_CST) |=> (cst_q[2:0] == $past(conn_lvl[2:0])));

  // R4: data sticky clear by write of one
  p_data_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFF_DST && wr_data[11] && !data_set[11]) |=> !dst_q[11]);

  // R7: no interrupt without enable
  p_irq_needs_ie_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ctrl_q[IE_BIT]);

  // R7: an enabled pending condition raises the line
  p_irq_raised_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[IE_BIT] && (cst_q[12] || dst_q[4])) |-> irq);

  // R11: set wins over a same-cycle clear
  p_set_beats_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFF_CST && wr_data[7] && conn_set[7]) |=> cst_q[7]);
endmodule

bind scsi_stat_regs scsi_stat_regs_chk i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .conn_set(conn_set), .data_set(data_set), .conn_lvl(conn_lvl),
  .cst_q(cst_q), .dst_q(dst_q), .ctrl_q(ctrl_q), .irq(irq));

// File: tb/test_scsi_stat_regs.sv
module test_scsi_stat_regs;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [6:0]  addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [15:0] conn_set = '0, data_set = '0, conn_lvl = '0, data_lvl = '0;
  logic [2:0]  det_id = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;

  // bench model
  logic [15:0] m_ctrl = '0;
  logic [13:0] m_cst = '0, m_dst = '0;
  logic [2:0]  m_id = '0, m_sel = '0, m_det = '0;
  logic [7:0]  m_data = '0;
  logic [1:0]  m_mode = '0;

  scsi_stat_regs i_scsi_stat_regs (.*);

  always #(CLK_P/2) clk = ~clk;

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog: run did not complete (all requirements)");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic bit c_sticky(int b); return b inside {13,12,11,9,8,7,3}; endfunction
  function automatic bit c_level(int b);  return b inside {0,1,2,4,5,6}; endfunction
  function automatic bit d_sticky(int b); return b inside {13,11,10,4,3}; endfunction
  function automatic bit d_level(int b);  return b inside {0,1,2}; endfunction

  function automatic logic exp_ci();
    return m_cst[13] | m_cst[12] | m_cst[11] | m_cst[9] | m_cst[8] | m_cst[7];
  endfunction
  function automatic logic exp_di();
    return m_dst[13] | m_dst[11] | m_dst[10] | m_dst[4];
  endfunction

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic rd(input logic [6:0] a, output logic [15:0] v);
    addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic verify_all(string tag);
    logic [15:0] v;
    rd(7'h0C, v); chk("R7", {tag, " ctrl"}, v, m_ctrl);
    rd(7'h10, v); chk("R8", {tag, " id"}, v, {13'd0, m_id});
    rd(7'h14, v); chk("R8", {tag, " sel"}, v, {13'd0, m_sel});
    rd(7'h18, v); chk("R9", {tag, " det"}, v, {13'd0, m_det});
    rd(7'h20, v); chk("R8", {tag, " data"}, v, {8'd0, m_data});
    rd(7'h24, v); chk("R8", {tag, " mode"}, v, {14'd0, m_mode});
    rd(7'h48, v); chk("R2/R3/R5/R6", {tag, " cstat"}, v, {exp_ci(), exp_di(), m_cst});
    rd(7'h4C, v); chk("R4/R5/R6", {tag, " dstat"}, v, {exp_ci(), exp_di(), m_dst});
    rd(7'h49, v); chk("R10", {tag, " misaligned read"}, v, 16'h0);
    rd(7'h30, v); chk("R10", {tag, " unmapped read"}, v, 16'h0);
    chk("R7", {tag, " irq"}, {15'd0, irq}, {15'd0, m_ctrl[0] & (exp_ci() | exp_di())});
  endtask

  task automatic step(string tag, logic w, logic [6:0] a, logic [15:0] d,
                      logic [15:0] cs, logic [15:0] ds, logic [15:0] cl,
                      logic [15:0] dl, logic [2:0] dt);
    logic [13:0] nc, nd;
    @(negedge clk);
    wr_en = w; addr = a; wr_data = d;
    conn_set = cs; data_set = ds; conn_lvl = cl; data_lvl = dl; det_id = dt;
    @(posedge clk);
    #1;
    wr_en = 1'b0; conn_set = '0; data_set = '0;
    for (int b = 0; b < 14; b++) begin
      if (c_sticky(b))      nc[b] = cs[b] | (m_cst[b] & ~(w && a == 7'h48 && d[b]));
      else if (c_level(b))  nc[b] = cl[b];
      else                  nc[b] = (w && a == 7'h48) ? d[b] : m_cst[b];
      if (d_sticky(b))      nd[b] = ds[b] | (m_dst[b] & ~(w && a == 7'h4C && d[b]));
      else if (d_level(b))  nd[b] = dl[b];
      else                  nd[b] = (w && a == 7'h4C) ? d[b] : m_dst[b];
    end
    m_cst = nc; m_dst = nd; m_det = dt;
    if (w) begin
      if (a == 7'h0C) m_ctrl = d;
      if (a == 7'h10) m_id = d[2:0];
      if (a == 7'h14) m_sel = d[2:0];
      if (a == 7'h20) m_data = d[7:0];
      if (a == 7'h24) m_mode = d[1:0];
    end
    verify_all(tag);
  endtask

  initial begin
    logic [6:0] alist [12];
    alist = '{7'h0C, 7'h10, 7'h14, 7'h18, 7'h20, 7'h24, 7'h48, 7'h4C,
              7'h4A, 7'h0D, 7'h30, 7'h11};
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    verify_all("R1 in reset");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    verify_all("R1 after reset");

    // R2 / R5: set, write zero keeps, write one clears
    step("R2 set", 0, 7'h48, 0, 16'h0800, 0, 0, 0, 0);
    step("R2 write0", 1, 7'h48, 16'h0000, 0, 0, 0, 0, 0);
    step("R7 ie on", 1, 7'h0C, 16'h0001, 0, 0, 0, 0, 0);
    step("R2 write1", 1, 7'h48, 16'h0800, 0, 0, 0, 0, 0);
    // R3: levels and writable bit 10, ro bits ignore writes
    step("R3 lvl", 1, 7'h48, 16'hFFFF, 0, 0, 16'h0075, 0, 0);
    // R6 / R4: data conditions one by one
    step("R6 dne", 0, 7'h4C, 0, 0, 16'h2000, 0, 16'h0005, 0);
    step("R4 clear", 1, 7'h4C, 16'hFFFF, 0, 0, 0, 0, 0);
    step("R4 mis", 0, 7'h4C, 0, 0, 16'h0010, 0, 0, 0);
    step("R7 ie off", 1, 7'h0C, 16'h0000, 0, 0, 0, 0, 0);
    // R11: collision of set and clear
    step("R11 collide", 1, 7'h48, 16'h0080, 16'h0080, 0, 0, 0, 0);
    step("R11 data collide", 1, 7'h4C, 16'h0400, 0, 16'h0400, 0, 0, 0);
    // R8 masking, R9 detector, R10 misaligned
    step("R8 id", 1, 7'h10, 16'hFFFF, 0, 0, 0, 0, 3'd5);
    step("R9 det write", 1, 7'h18, 16'hFFFF, 0, 0, 0, 0, 3'd5);
    step("R8 mode", 1, 7'h24, 16'hFFFF, 0, 0, 0, 0, 0);
    step("R8 data", 1, 7'h20, 16'hABCD, 0, 0, 0, 0, 0);
    step("R10 misaligned", 1, 7'h21, 16'h0011, 0, 0, 0, 0, 0);
    step("R10 unmapped", 1, 7'h30, 16'hFFFF, 0, 0, 0, 0, 0);

    for (int i = 0; i < 400; i++) begin
      logic [6:0] a;
      a = alist[$urandom_range(0, 11)];
      step("random", $urandom_range(0, 1) == 1, a, 16'($urandom),
           16'($urandom & $urandom & $urandom), 16'($urandom & $urandom & $urandom),
           16'($urandom), 16'($urandom), 3'($urandom));
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule